// File: doc/BRIEF.md
# Pseudo-Digital Header Detector

This block looks for a four-symbol start marker inside a stream of digitised analog samples that arrive one byte per accepted transfer. Every sample is sorted into one of three classes by two programmable 8-bit thresholds. The low-level ceiling gives a logic 0 and the high-level floor gives a logic 1. A sample that meets neither test, or both, is invalid. The block keeps a short history of the recent classes. When the four most recent classes read 0, 1, 0, 1 in arrival order, it raises a single-cycle header pulse.

The search can run in two ways. In triggered operation, a trigger pulse opens a search window and the first header found closes it again. In free-running operation, the block searches whenever it is armed, with no trigger needed, and headers that overlap are all reported. Dropping the arm input throws away any partial match.

The class of each sample is sent out on a valid/ready output stream through a single register stage. The sample input takes a new byte when the output register is empty or is being drained in the same cycle. While the consumer holds ready low and the output register is full, the input ready is low. A stalled byte is not sampled and does not enter the history. The thresholds, mode, arm and trigger inputs are plain control pins.

Top module: `pd_header_detector`

## Requirements
- R1: An accepted sample at or below `lo_lim_i` (and below `hi_lim_i`) is classified 2'b00 (zero). A sample at or above `hi_lim_i` (and above `lo_lim_i`) is classified 2'b01 (one). A sample strictly between the two limits is classified 2'b10 (invalid). The code 2'b11 is never produced.
- R2: When the limits overlap, a sample that satisfies both the zero test and the one test is classified 2'b10 (invalid).
- R3: A one-cycle `hdr_found_o` pulse appears in the cycle after the register edge that accepts the fourth sample of a 0,1,0,1 class sequence, in arrival order, oldest first. No other order of four valid classes (for example 1,0,1,0) produces a pulse.
- R4: An invalid sample empties the match history. A header needs four valid samples that arrive after the last invalid one.
- R5: While `arm_i` is low, the history is cleared, `hdr_found_o` stays low, and samples accepted in that time do not count toward a later header.
- R6: With `free_run_i` low, samples count only from the cycle after a `trig_i` pulse taken while armed. After the first header is reported, the window closes and stays closed until the next trigger.
- R7: With `free_run_i` high, the search runs whenever the block is armed and `trig_i` has no effect. Overlapping headers are each reported, so 0,1,0,1,0,1 gives two pulses.
- R8: `s_ready_o` is high exactly when `m_valid_o` is low or `m_ready_i` is high. While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o` and `m_class_o` hold their values. A sample offered while `s_ready_o` is low is neither classified nor added to the history.
- R9: After reset, `hdr_found_o` and `m_valid_o` are low and `s_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Enables the header search; low clears the history |
| free_run_i | input | 1 | 1: search without trigger; 0: search opened by trigger |
| trig_i | input | 1 | Trigger pulse that opens the search window in triggered operation |
| lo_lim_i | input | 8 | Ceiling for a logic-0 level |
| hi_lim_i | input | 8 | Floor for a logic-1 level |
| s_valid_i | input | 1 | Sample stream valid |
| s_ready_o | output | 1 | Sample stream ready |
| s_sample_i | input | 8 | Digitised sample |
| m_valid_o | output | 1 | Class stream valid |
| m_ready_i | input | 1 | Class stream ready |
| m_class_o | output | 2 | Class: 00 zero, 01 one, 10 invalid |
| hdr_found_o | output | 1 | Single-cycle header-found pulse |

## Verification
The hardest case to reach from the ports is the interaction between the triggered search window and the history. The bench must show that samples sent before a trigger, or after the first header, leave no trace. To do this it sends a complete 0,1,0,1 burst before any trigger. It then triggers once and sends two full bursts, and counts the pulses to confirm that exactly one appears. Back-pressure is reached by holding the consumer's ready low while a second sample waits on the input. The bench checks that the output holds and that only the released sample gets through.

// File: rtl/hdr_det_pkg.sv
package hdr_det_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_ONE  = 2'b01,
    CLS_BAD  = 2'b10
  } sym_cls_e;

endpackage

// File: rtl/hdr_classify.sv
module hdr_classify
  import hdr_det_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] lo_lim_i,
  input  logic [SAMPLE_W-1:0] hi_lim_i,
  output sym_cls_e            cls_o
);

  logic is_low;
  logic is_high;

  assign is_low  = (sample_i <= lo_lim_i);
  assign is_high = (sample_i >= hi_lim_i);

  // An ambiguous sample (both tests true) is treated as invalid.
  always_comb begin
    unique case ({is_high, is_low})
      2'b01:   cls_o = CLS_ZERO;
      2'b10:   cls_o = CLS_ONE;
      default: cls_o = CLS_BAD;
    endcase
  end

endmodule

// File: rtl/hdr_search_gate.sv
module hdr_search_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic free_run_i,
  input  logic trig_i,
  input  logic hit_i,
  output logic active_o
);

  logic win_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
    end else if (!arm_i || free_run_i) begin
      win_q <= 1'b0;
    end else if (trig_i) begin
      win_q <= 1'b1;
    end else if (hit_i) begin
      win_q <= 1'b0;
    end
  end

  assign active_o = arm_i && (free_run_i || win_q);

  // R6: without a trigger, a closed window stays closed
  AST_NO_OPEN_WITHOUT_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_run_i && !win_q && !trig_i) |=> !win_q); // R6

  // R6: a detected header closes the triggered window
  AST_HIT_CLOSES_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_run_i && hit_i && !trig_i) |=> !win_q); // R6

endmodule

// File: rtl/hdr_history.sv
module hdr_history
  import hdr_det_pkg::*;
#(
  parameter int               HDR_LEN = 4,
  parameter logic [HDR_LEN-1:0] HDR_PAT = 4'b0101
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     active_i,
  input  logic     push_i,
  input  sym_cls_e cls_i,
  output logic     hit_o,
  output logic     hdr_o
);

  localparam int FILL_W = $clog2(HDR_LEN + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HDR_LEN);

  logic [HDR_LEN-1:0] hist_q;
  logic [FILL_W-1:0]  fill_q;
  logic               upd_q;
  logic               hdr_q;
  logic [HDR_LEN-1:0] hist_shift;

  // Newest class enters at bit 0; the oldest sits at the MSB.
  generate
    if (HDR_LEN > 1) begin : g_shift
      assign hist_shift = {hist_q[HDR_LEN-2:0], (cls_i == CLS_ONE)};
    end else begin : g_single
      assign hist_shift = (cls_i == CLS_ONE);
    end
  endgenerate

  assign hit_o = upd_q && (fill_q == FILL_MAX) && (hist_q == HDR_PAT);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
      upd_q  <= 1'b0;
      hdr_q  <= 1'b0;
    end else if (!active_i) begin
      hist_q <= '0;
      fill_q <= '0;
      upd_q  <= 1'b0;
      hdr_q  <= 1'b0;
    end else begin
      upd_q <= push_i;
      hdr_q <= hit_o;
      if (push_i) begin
        if (cls_i == CLS_BAD) begin
          hist_q <= '0;
          fill_q <= '0;
        end else begin
          hist_q <= hist_shift;
          if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
        end
      end
    end
  end

  assign hdr_o = hdr_q;

  // R4: an invalid sample empties the history
  AST_BAD_EMPTIES_HIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && push_i && cls_i == CLS_BAD) |=> (fill_q == '0)); // R4

  // R3: header pulse lasts a single cycle
  AST_HDR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_q |=> !hdr_q); // R3

  // R3: pulse only after a full history was updated
  AST_HDR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hdr_q) |-> $past(fill_q) == FILL_MAX); // R3

endmodule

// File: rtl/pd_header_detector.sv
module pd_header_detector
  import hdr_det_pkg::*;
#(
  parameter int                 SAMPLE_W = 8,
  parameter int                 HDR_LEN  = 4,
  parameter logic [HDR_LEN-1:0] HDR_PAT  = 4'b0101
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                free_run_i,
  input  logic                trig_i,
  input  logic [SAMPLE_W-1:0] lo_lim_i,
  input  logic [SAMPLE_W-1:0] hi_lim_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [SAMPLE_W-1:0] s_sample_i,
  output logic                m_valid_o,
  input  logic                m_ready_i,
  output logic [1:0]          m_class_o,
  output logic                hdr_found_o
);

  sym_cls_e cls_now;
  sym_cls_e cls_q;
  logic     out_vld_q;
  logic     accept;
  logic     active;
  logic     hit;

  assign s_ready_o = !out_vld_q || m_ready_i;
  assign accept    = s_valid_i && s_ready_o;

  hdr_classify #(.SAMPLE_W(SAMPLE_W)) u_classify (
    .sample_i (s_sample_i),
    .lo_lim_i (lo_lim_i),
    .hi_lim_i (hi_lim_i),
    .cls_o    (cls_now)
  );

  hdr_search_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .free_run_i (free_run_i),
    .trig_i     (trig_i),
    .hit_i      (hit),
    .active_o   (active)
  );

  hdr_history #(.HDR_LEN(HDR_LEN), .HDR_PAT(HDR_PAT)) u_history (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .push_i   (accept),
    .cls_i    (cls_now),
    .hit_o    (hit),
    .hdr_o    (hdr_found_o)
  );

  // Single output register stage for the class stream.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      cls_q     <= CLS_ZERO;
    end else if (accept) begin
      out_vld_q <= 1'b1;
      cls_q     <= cls_now;
    end else if (m_ready_i) begin
      out_vld_q <= 1'b0;
    end
  end

  assign m_valid_o = out_vld_q;
  assign m_class_o = cls_q;

  // R8: a stalled output holds its value
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_class_o))); // R8

  // R1: the reserved class code never leaves the block
  AST_CLASS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> (m_class_o != 2'b11)); // R1

  // R5: no header pulse while disarmed
  AST_NOT_ARMED_NO_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !hdr_found_o); // R5

endmodule

// File: tb/pd_header_detector_tb.sv
module pd_header_detector_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       arm, free_run, trig;
  logic [7:0] lo_lim, hi_lim;
  logic       s_valid, s_ready;
  logic [7:0] s_sample;
  logic       m_valid, m_ready;
  logic [1:0] m_class;
  logic       hdr;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done   = 1'b0;

  localparam logic [7:0] V_LO  = 8'h10;
  localparam logic [7:0] V_HI  = 8'hF0;
  localparam logic [7:0] V_MID = 8'h80;

  always #2.5 clk = ~clk;

  pd_header_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .free_run_i(free_run),
    .trig_i(trig), .lo_lim_i(lo_lim), .hi_lim_i(hi_lim),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_sample_i(s_sample),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_class_o(m_class),
    .hdr_found_o(hdr)
  );

  always @(posedge clk) if (rst_n && hdr) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cls(input logic [7:0] s);
    bit z = (s <= lo_lim);
    bit o = (s >= hi_lim);
    if (z && !o) return 0;
    if (o && !z) return 1;
    return 2;
  endfunction

  task automatic send(input logic [7:0] s, input string req);
    @(negedge clk);
    s_valid  = 1'b1;
    s_sample = s;
    @(posedge clk);
    #1;
    chk(req, int'(m_class), exp_cls(s));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    s_valid = 1'b0;
    trig    = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic burst(input logic [7:0] a, b, c, d, input string req);
    send(a, req); send(b, req); send(c, req); send(d, req);
  endtask

  task automatic clear_hist();
    @(negedge clk);
    arm = 1'b0;
    idle(2);
    @(negedge clk);
    arm = 1'b1;
  endtask

  task automatic t_reset();
    chk("R9 hdr", int'(hdr), 0);
    chk("R9 m_valid", int'(m_valid), 0);
    chk("R9 s_ready", int'(s_ready), 1);
  endtask

  task automatic t_classify();
    lo_lim = 8'h40; hi_lim = 8'hC0;
    send(8'h00, "R1 zero"); send(8'h40, "R1 zero edge");
    send(8'h41, "R1 mid low"); send(8'hBF, "R1 mid high");
    send(8'hC0, "R1 one edge"); send(8'hFF, "R1 one");
    chk("R1 code 10 mid", int'(exp_cls(8'h80)), 2);
    idle(1);
  endtask

  task automatic t_overlap();
    lo_lim = 8'h80; hi_lim = 8'h60;
    send(8'h70, "R2 both");
    chk("R2 invalid code", int'(m_class), 2);
    send(8'h50, "R2 zero"); send(8'h90, "R2 one");
    idle(1);
    lo_lim = 8'h40; hi_lim = 8'hC0;
  endtask

  task automatic t_header();
    int p0;
    free_run = 1'b1;
    clear_hist();
    p0 = pulses;
    burst(V_LO, V_HI, V_LO, V_HI, "R3 class");
    chk("R3 no pulse at fourth edge", int'(hdr), 0);
    idle(1);
    chk("R3 pulse next cycle", int'(hdr), 1);
    idle(1);
    chk("R3 pulse one cycle", int'(hdr), 0);
    burst(V_HI, V_LO, V_HI, V_LO, "R3 class");
    idle(3);
    chk("R3 only 0101 matches", pulses - p0, 1);
  endtask

  task automatic t_free_overlap();
    int p0;
    free_run = 1'b1;
    clear_hist();
    p0 = pulses;
    @(negedge clk); trig = 1'b1;
    burst(V_LO, V_HI, V_LO, V_HI, "R7 class");
    send(V_LO, "R7 class"); send(V_HI, "R7 class");
    idle(3);
    chk("R7 overlapping headers", pulses - p0, 2);
  endtask

  task automatic t_invalid();
    int p0;
    free_run = 1'b1;
    clear_hist();
    p0 = pulses;
    send(V_LO, "R4 class"); send(V_HI, "R4 class"); send(V_MID, "R4 class");
    send(V_LO, "R4 class"); send(V_HI, "R4 class");
    idle(3);
    chk("R4 invalid breaks match", pulses - p0, 0);
    send(V_LO, "R4 class"); send(V_HI, "R4 class");
    idle(3);
    chk("R4 four valid after invalid", pulses - p0, 1);
  endtask

  task automatic t_disarm();
    int p0;
    free_run = 1'b1;
    clear_hist();
    p0 = pulses;
    send(V_LO, "R5 class"); send(V_HI, "R5 class");
    clear_hist();
    send(V_LO, "R5 class"); send(V_HI, "R5 class");
    idle(3);
    chk("R5 disarm clears history", pulses - p0, 0);
    @(negedge clk); arm = 1'b0;
    burst(V_LO, V_HI, V_LO, V_HI, "R5 class while disarmed");
    idle(3);
    chk("R5 no pulse disarmed", pulses - p0, 0);
    @(negedge clk); arm = 1'b1;
  endtask

  task automatic t_trig();
    int p0;
    free_run = 1'b0;
    clear_hist();
    p0 = pulses;
    burst(V_LO, V_HI, V_LO, V_HI, "R6 class");
    idle(3);
    chk("R6 no search before trigger", pulses - p0, 0);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    burst(V_LO, V_HI, V_LO, V_HI, "R6 class");
    burst(V_LO, V_HI, V_LO, V_HI, "R6 class");
    idle(3);
    chk("R6 one header per trigger", pulses - p0, 1);
  endtask

  task automatic t_stall();
    int p0;
    free_run = 1'b1;
    clear_hist();
    p0 = pulses;
    send(V_LO, "R8 class"); send(V_HI, "R8 class"); send(V_LO, "R8 class");
    @(negedge clk);
    m_ready = 1'b0;
    s_valid = 1'b0;
    @(negedge clk);
    chk("R8 ready low when full", int'(s_ready), m_ready ? 1 : !m_valid);
    s_valid = 1'b1;
    s_sample = V_MID;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 held valid", int'(m_valid), 1);
    chk("R8 held class", int'(m_class), 0);
    chk("R8 s_ready low", int'(s_ready), 0);
    @(negedge clk);
    s_sample = V_HI;
    m_ready  = 1'b1;
    @(posedge clk);
    #1;
    chk("R8 released sample", int'(m_class), 1);
    idle(3);
    chk("R8 stalled sample not in history", pulses - p0, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; free_run = 1'b1; trig = 1'b0;
    lo_lim = 8'h40; hi_lim = 8'hC0;
    s_valid = 1'b0; s_sample = 8'h00; m_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_classify();
    t_overlap();
    arm = 1'b1;
    t_header();
    t_free_overlap();
    t_invalid();
    t_disarm();
    t_trig();
    t_stall();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule